// File: doc/BRIEF.md
# Integer Execute Unit with Operand Complement Modifiers

This block is the integer execute stage of a 64-bit core. Each issued operation carries a 3-bit operation code and a 2-bit modifier. The modifier can complement one operand before the operation or, for logic operations only, the result after it. The meaning of "complement" follows the operation class. For the adder it is a two's-complement negation, so subtraction is an add with a negated source and there is no separate subtract path. For logic and shift operations it is a bitwise inversion, so nand, nor, xnor and and-not need no opcodes of their own.

The block evaluates the operation in combinational logic and captures the outcome in one register stage. An operation presented with `in_valid` produces `out_valid` one cycle later, together with the result. Combinations the modifier does not allow are rejected. A rejected operation still produces `out_valid`, but with a zero result and the `illegal` flag raised.

Top module: `alu_cmod_exec`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `out_valid`, `illegal` and `result` are all zero.
- R2: `out_valid` is high in exactly those cycles that directly follow a cycle with `in_valid` high. Back-to-back operations give back-to-back results.
- R3: Operation code 0 (add) returns `src_a + src_b` modulo 2^64. Modifier 2 returns `src_a - src_b`. Modifier 1 returns `src_b - src_a`.
- R4: Operation codes 1, 2 and 3 are and, or and xor. Modifier 1 inverts every bit of `src_a` first. Modifier 2 inverts every bit of `src_b` first.
- R5: For codes 1, 2 and 3, modifier 3 inverts every bit of the result, which gives nand, nor and xnor.
- R6: Codes 4, 5 and 6 are shift left, logical shift right and arithmetic shift right of `src_a`. The shift amount is the low 6 bits of `src_b`, and the upper bits of `src_b` have no effect. Modifier 1 inverts `src_a` before the shift.
- R7: The following combinations are illegal: modifier 3 on add, modifier 2 or 3 on any shift, and any modifier on code 7. An illegal operation returns `result` zero with `illegal` high in its `out_valid` cycle.
- R8: `illegal` is never high without `out_valid`. In a cycle after `in_valid` was low, `result` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 3 | Operation code (0 add, 1 and, 2 or, 3 xor, 4 shl, 5 shr, 6 sar, 7 reserved) |
| cmod | input | 2 | Complement modifier (0 none, 1 first source, 2 second source, 3 result) |
| src_a | input | 64 | First source operand |
| src_b | input | 64 | Second source operand / shift amount |
| out_valid | output | 1 | Result present this cycle |
| result | output | 64 | Registered result |
| illegal | output | 1 | Operation was rejected; result is zero |

## Verification
Every result, the `illegal` flag and `out_valid` are due on the first rising edge after the operation is driven, which is one register stage. The bench drives inputs on the falling edge and samples outputs on the next falling edge. That places each sample half a cycle after the only edge that could have changed the value. The back-to-back test adds a second falling-edge sample to confirm that `out_valid` drops exactly one cycle after the last operation. The hold test confirms that `result` is unchanged across an idle cycle.

// File: rtl/alu_cmod_pkg.sv
package alu_cmod_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_AND = 3'd1,
    OP_OR  = 3'd2,
    OP_XOR = 3'd3,
    OP_SHL = 3'd4,
    OP_SHR = 3'd5,
    OP_SAR = 3'd6,
    OP_RSV = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    CM_NONE = 2'd0,
    CM_SRC1 = 2'd1,
    CM_SRC2 = 2'd2,
    CM_RES  = 2'd3
  } cmod_e;

  typedef enum logic [1:0] {
    CL_ARITH = 2'd0,
    CL_LOGIC = 2'd1,
    CL_SHIFT = 2'd2,
    CL_NONE  = 2'd3
  } opclass_e;

  // Operation class decides how the complement marker is interpreted
  function automatic opclass_e op_class(input logic [2:0] op);
    case (op)
      OP_ADD:                 op_class = CL_ARITH;
      OP_AND, OP_OR, OP_XOR:  op_class = CL_LOGIC;
      OP_SHL, OP_SHR, OP_SAR: op_class = CL_SHIFT;
      default:                op_class = CL_NONE;
    endcase
  endfunction

  // Modifier legality per class
  function automatic logic cmod_illegal(input opclass_e cls, input logic [1:0] cm);
    case (cls)
      CL_ARITH: cmod_illegal = (cm == CM_RES);
      CL_LOGIC: cmod_illegal = 1'b0;
      CL_SHIFT: cmod_illegal = (cm == CM_SRC2) || (cm == CM_RES);
      default:  cmod_illegal = 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/alu_opnd_cond.sv
// Conditions one source operand: pass, invert, or negate.
module alu_opnd_cond #(
  parameter int W = 64
) (
  input  logic         sel,
  input  logic         twos,
  input  logic [W-1:0] x,
  output logic [W-1:0] y
);

  function automatic logic [W-1:0] f_inv(input logic [W-1:0] v);
    f_inv = ~v;
  endfunction

  function automatic logic [W-1:0] f_neg(input logic [W-1:0] v);
    f_neg = f_inv(v) + {{(W-1){1'b0}}, 1'b1};
  endfunction

  always_comb begin
    if (!sel)      y = x;
    else if (twos) y = f_neg(x);
    else           y = f_inv(x);
  end

endmodule

// File: rtl/alu_legal_chk.sv
// Decides whether op/modifier combination is allowed.
module alu_legal_chk
  import alu_cmod_pkg::*;
(
  input  logic [2:0] op,
  input  logic [1:0] cmod,
  output opclass_e   cls,
  output logic       bad
);

  always_comb begin
    cls = op_class(op);
    bad = cmod_illegal(cls, cmod);
  end

endmodule

// File: rtl/alu_func_unit.sv
// Combinational operation on the conditioned operands.
module alu_func_unit
  import alu_cmod_pkg::*;
#(
  parameter int W   = 64,
  parameter int SHW = $clog2(W)
) (
  input  logic [2:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         res_inv,
  output logic [W-1:0] y
);

  logic [SHW-1:0] amt;
  logic [W-1:0]   raw;

  assign amt = b[SHW-1:0];

  function automatic logic [W-1:0] f_add(input logic [W-1:0] p, input logic [W-1:0] q);
    f_add = p + q;
  endfunction

  function automatic logic [W-1:0] f_sar(input logic [W-1:0] p, input logic [SHW-1:0] s);
    f_sar = W'($signed(p) >>> s);
  endfunction

  always_comb begin
    case (op)
      OP_ADD:  raw = f_add(a, b);
      OP_AND:  raw = a & b;
      OP_OR:   raw = a | b;
      OP_XOR:  raw = a ^ b;
      OP_SHL:  raw = a << amt;
      OP_SHR:  raw = a >> amt;
      OP_SAR:  raw = f_sar(a, amt);
      default: raw = '0;
    endcase
    y = res_inv ? ~raw : raw;
  end

endmodule

// File: rtl/alu_cmod_exec.sv
module alu_cmod_exec
  import alu_cmod_pkg::*;
#(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [2:0]   op,
  input  logic [1:0]   cmod,
  input  logic [W-1:0] src_a,
  input  logic [W-1:0] src_b,
  output logic         out_valid,
  output logic [W-1:0] result,
  output logic         illegal
);

  localparam int NSRC = 2;

  opclass_e       cls;
  logic           ill_now;
  logic           twos_sel;
  logic           res_inv;
  logic [W-1:0]   src   [NSRC];
  logic [W-1:0]   cond  [NSRC];
  logic [W-1:0]   fu_y;
  logic [W-1:0]   next_res;

  assign src[0] = src_a;
  assign src[1] = src_b;

  alu_legal_chk u_legal (
    .op   (op),
    .cmod (cmod),
    .cls  (cls),
    .bad  (ill_now)
  );

  assign twos_sel = (cls == CL_ARITH);
  assign res_inv  = (cls == CL_LOGIC) && (cmod == CM_RES);

  for (genvar gi = 0; gi < NSRC; gi++) begin : g_cond
    alu_opnd_cond #(.W(W)) u_cond (
      .sel  (cmod == 2'(gi + 1)),
      .twos (twos_sel),
      .x    (src[gi]),
      .y    (cond[gi])
    );
  end

  alu_func_unit #(.W(W)) u_fu (
    .op      (op),
    .a       (cond[0]),
    .b       (cond[1]),
    .res_inv (res_inv),
    .y       (fu_y)
  );

  assign next_res = ill_now ? '0 : fu_y;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      illegal   <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      illegal   <= in_valid && ill_now;
      if (in_valid) result <= next_res;
    end
  end

endmodule

// File: rtl/alu_cmod_exec_chk.sv
module alu_cmod_exec_chk #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [2:0]   op,
  input logic [1:0]   cmod,
  input logic         ill_now,
  input logic         out_valid,
  input logic [W-1:0] result,
  input logic         illegal
);

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R2
  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R2
  AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (result == '0)); // R7
  AST_SHIFT_AMT_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op[2] && op != 3'd7 && cmod == 2'd2) |=> illegal); // R7
  AST_RSV_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'd7) |=> illegal); // R7
  AST_DECODE_TO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !ill_now) |=> !illegal); // R7
  AST_ILLEGAL_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> out_valid); // R8
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result)); // R8

endmodule

bind alu_cmod_exec alu_cmod_exec_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .op        (op),
  .cmod      (cmod),
  .ill_now   (ill_now),
  .out_valid (out_valid),
  .result    (result),
  .illegal   (illegal)
);

// File: tb/sim_alu_cmod_exec.sv
module sim_alu_cmod_exec;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  op;
  logic [1:0]  cmod;
  logic [63:0] src_a, src_b;
  logic        out_valid;
  logic [63:0] result;
  logic        illegal;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  alu_cmod_exec u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .cmod(cmod),
    .src_a(src_a), .src_b(src_b), .out_valid(out_valid), .result(result),
    .illegal(illegal)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive one op on a falling edge, sample one cycle later on the next falling edge
  task automatic run_op(input string tag, input logic [2:0] o, input logic [1:0] m,
                        input logic [63:0] a, input logic [63:0] b,
                        input logic [63:0] exp, input logic exp_ill);
    @(negedge clk);
    in_valid = 1'b1; op = o; cmod = m; src_a = a; src_b = b;
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " out_valid"}, {63'd0, out_valid}, 64'd1);
    chk({tag, " result"}, result, exp);
    chk({tag, " illegal"}, {63'd0, illegal}, {63'd0, exp_ill});
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b1; op = 3'd0; cmod = 2'd0;
    src_a = 64'd3; src_b = 64'd4;
    repeat (3) @(negedge clk);
    chk("R1 out_valid in reset", {63'd0, out_valid}, 64'd0);
    chk("R1 result in reset", result, 64'd0);
    chk("R1 illegal in reset", {63'd0, illegal}, 64'd0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out_valid after reset", {63'd0, out_valid}, 64'd0);
    chk("R1 result after reset", result, 64'd0);
  endtask

  task automatic t_add();
    run_op("R3 add", 3'd0, 2'd0, 64'd5, 64'd7, 64'd12, 1'b0);
    run_op("R3 a-b", 3'd0, 2'd2, 64'd100, 64'd30, 64'd70, 1'b0);
    run_op("R3 b-a", 3'd0, 2'd1, 64'd30, 64'd100, 64'd70, 1'b0);
    run_op("R3 wrap", 3'd0, 2'd0, '1, 64'd1, 64'd0, 1'b0);
    run_op("R3 underflow", 3'd0, 2'd2, 64'd0, 64'd1, '1, 1'b0);
  endtask

  task automatic t_logic();
    logic [63:0] a = 64'h0123_4567_F0F0_A5A5;
    logic [63:0] b = 64'hFFFF_0000_FF00_3C3C;
    run_op("R4 and", 3'd1, 2'd0, a, b, a & b, 1'b0);
    run_op("R4 and-not b", 3'd1, 2'd2, a, b, a & ~b, 1'b0);
    run_op("R4 or-not a", 3'd2, 2'd1, a, b, ~a | b, 1'b0);
    run_op("R4 xor-not b", 3'd3, 2'd2, a, b, a ^ ~b, 1'b0);
    run_op("R5 nand", 3'd1, 2'd3, a, b, ~(a & b), 1'b0);
    run_op("R5 nor", 3'd2, 2'd3, a, b, ~(a | b), 1'b0);
    run_op("R5 xnor", 3'd3, 2'd3, a, b, ~(a ^ b), 1'b0);
  endtask

  task automatic t_shift();
    run_op("R6 shl upper amt bits ignored", 3'd4, 2'd0, 64'd1, 64'hFFFF_0000_0000_0043, 64'd8, 1'b0);
    run_op("R6 shr 63", 3'd5, 2'd0, 64'h8000_0000_0000_0000, 64'd63, 64'd1, 1'b0);
    run_op("R6 sar 4", 3'd6, 2'd0, 64'h8000_0000_0000_0000, 64'd4, 64'hF800_0000_0000_0000, 1'b0);
    run_op("R6 sar positive", 3'd6, 2'd0, 64'h4000_0000_0000_0000, 64'd2, 64'h1000_0000_0000_0000, 1'b0);
    run_op("R6 shl inverted a", 3'd4, 2'd1, 64'd0, 64'd4, 64'hFFFF_FFFF_FFFF_FFF0, 1'b0);
  endtask

  task automatic t_illegal();
    run_op("R7 add with result cmod", 3'd0, 2'd3, 64'd5, 64'd7, 64'd0, 1'b1);
    run_op("R7 shift amount cmod", 3'd4, 2'd2, 64'd1, 64'd1, 64'd0, 1'b1);
    run_op("R7 sar result cmod", 3'd6, 2'd3, 64'hF0, 64'd1, 64'd0, 1'b1);
    run_op("R7 reserved code", 3'd7, 2'd0, 64'd9, 64'd9, 64'd0, 1'b1);
  endtask

  task automatic t_hold();
    run_op("R8 setup", 3'd0, 2'd0, 64'd40, 64'd2, 64'd42, 1'b0);
    in_valid = 1'b0; src_a = 64'd1; src_b = 64'd1; op = 3'd7;
    @(negedge clk);
    chk("R8 out_valid idle", {63'd0, out_valid}, 64'd0);
    chk("R8 illegal idle", {63'd0, illegal}, 64'd0);
    chk("R8 result held", result, 64'd42);
  endtask

  task automatic t_b2b();
    @(negedge clk);
    in_valid = 1'b1; op = 3'd0; cmod = 2'd0; src_a = 64'd1; src_b = 64'd2;
    @(negedge clk);
    chk("R2 first out_valid", {63'd0, out_valid}, 64'd1);
    chk("R2 first result", result, 64'd3);
    op = 3'd3; src_a = 64'hFF; src_b = 64'h0F;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2 second out_valid", {63'd0, out_valid}, 64'd1);
    chk("R2 second result", result, 64'hF0);
    @(negedge clk);
    chk("R2 out_valid drops", {63'd0, out_valid}, 64'd0);
  endtask

  initial begin
    t_reset();
    t_add();
    t_logic();
    t_shift();
    t_illegal();
    t_hold();
    t_b2b();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule